// File: doc/BRIEF.md
# Chip-Select Memory Address Decoder

This block is a small memory subsystem behind a 16-bit CPU address bus. It carves the low kilobyte of the address space into four 128-byte read/write banks and one 512-byte read-only bank. Each bank is gated by a pair of chip-select inputs, one active high and one active low. A bank acts only when the first is 1 and the second is 0. A 2-to-4 decoder on two address bits picks the read/write bank, and a separate address bit steers accesses to the read-only bank.

Writes land on the rising clock edge. Reads are combinational: the single bank that drives its output places its byte on `rdata` through a one-hot OR mux, and `rd_oe` shows that some bank is driving. When no bank is enabled the bus reads as 0x00, which stands in for a floating bus. The read-only bank holds a fixed pattern set by a parameter. Accesses above 0x03FF, and write strobes aimed at the read-only range, are dropped and raise a registered error flag for one cycle.

Top module: `memmap_decoder`

## Requirements
- R1: With addr[15:10]=0 and addr[9]=0, addr[8:7] selects read/write bank 0..3 and addr[6:0] selects the byte inside it. This covers 0x0000-0x007F, 0x0080-0x00FF, 0x0100-0x017F and 0x0180-0x01FF, and the four banks hold independent contents.
- R2: A read/write-bank write takes effect at the rising clock edge on which wr_en=1. A read in a later cycle returns the written byte on rdata in the same cycle the address is presented.
- R3: While wr_en=1, no bank drives the bus: rd_oe=0 and rdata=0x00, even when rd_en=1. The write still takes place.
- R4: A read with rd_en=1, wr_en=0 in 0x0200-0x03FF returns the read-only byte. Its value is (addr[7:0] XOR ROM_SEED), inverted bitwise when addr[8]=1.
- R5: A write aimed at 0x0200-0x03FF leaves the read-only contents unchanged. dec_err is 1 in the cycle after that clock edge and 0 again after an idle edge.
- R6: An access (rd_en or wr_en) with any of addr[15:10] nonzero selects no bank. rdata stays 0x00 and rd_oe stays 0, no bank contents change (including the byte at addr[9:0]), and dec_err is 1 in the cycle after the edge.
- R7: With rd_en=0 and wr_en=0, rd_oe=0 and rdata=0x00, and dec_err is 0 after the next edge.
- R8: While rst_n=0, dec_err is 0 from the first clock edge on.
- R9: rd_oe=1 exactly when rd_en=1, wr_en=0 and addr[15:10]=0, and at most one bank drives at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and error flag update on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the error flag |
| addr | input | 16 | CPU byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Byte from the driving bank, 0x00 when none drives |
| rd_oe | output | 1 | High when a bank drives rdata |
| dec_err | output | 1 | One-cycle flag for an out-of-map access or a read-only write |

## Verification
The bench builds the block with its default geometry of four 128-byte banks and a 512-byte read-only bank. It overrides ROM_SEED to 0xC3 so that the read-only pattern differs from any plain address echo. This brings every bank boundary (0x007F/0x0080, 0x01FF/0x0200, 0x03FF/0x0400) within reach, along with the inverted upper half of the read-only bank. Aliasing is checked by writing at an out-of-map address whose low ten bits hit a live byte, then reading that byte back.

// File: rtl/memmap_pkg.sv
// Package: shared chip-select type and select-gating function.
// Assumes every device follows the two-input select table:
// active only when cs1=1 and cs2=0.
package memmap_pkg;

    typedef struct packed {
        logic cs1;
        logic cs2;
    } chip_sel_t;

    // Returns 1 when the select pair enables a device.
    function automatic logic sel_active(input chip_sel_t s);
        return s.cs1 & ~s.cs2;
    endfunction

endpackage

// File: rtl/memmap_addr_decode.sv
// Module: address decoder producing a select pair for each bank.
// Assumes the read/write region and the read-only region are equal in size
// (RAM_BANKS * 2**RAM_AW == 2**ROM_AW). Address bit ROM_AW splits them, and
// every bit above it must be zero for any device to be selected.
module memmap_addr_decode
    import memmap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_AW    = 7,
    parameter int ROM_AW    = 9,
    parameter int RAM_BANKS = 4
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             rd_en,
    input  logic                             wr_en,
    output chip_sel_t [RAM_BANKS-1:0]        ram_sel,
    output chip_sel_t                        rom_sel,
    output logic                             in_map
);
    localparam int BANK_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1;
    localparam int UPPER_LSB = ROM_AW + 1;

    logic [BANK_W-1:0] bank_idx;

    // Upper-bit check: only the low kilobyte is populated.
    always_comb begin
        in_map   = (addr[ADDR_W-1:UPPER_LSB] == '0);
        bank_idx = addr[RAM_AW +: BANK_W];
    end

    // 2-to-4 style decoder: one cs1 per bank, cs2 tied to the region bit.
    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_ram_sel
        always_comb begin
            ram_sel[b].cs1 = in_map & (bank_idx == BANK_W'(b));
            ram_sel[b].cs2 = addr[ROM_AW];
        end
    end

    // Read-only select: region bit and read strobe high, blocked by any write or out-of-map bit.
    always_comb begin
        rom_sel.cs1 = addr[ROM_AW] & rd_en;
        rom_sel.cs2 = ~in_map | wr_en;
    end

endmodule

// File: rtl/memmap_ram_bank.sv
// Module: one read/write byte bank behind a select pair.
// Assumes the write strobe wins over the read strobe; the output is zero
// whenever the bank is not driving (stands in for a floating bus).
module memmap_ram_bank
    import memmap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  chip_sel_t         sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              active;

    // Select gating and read path.
    always_comb begin
        active = sel_active(sel);
        oe     = active & rd_en & ~wr_en;
        dout   = oe ? mem[addr] : '0;
    end

    // Synchronous write when selected.
    always_ff @(posedge clk) begin
        if (active && wr_en) begin
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/memmap_rom_bank.sv
// Module: read-only byte bank whose contents come from a parameter.
// Assumes the decoder has already folded the strobes into the select pair.
// Pattern: low address byte XOR ROM_SEED, fully inverted in the upper half.
module memmap_rom_bank
    import memmap_pkg::*;
#(
    parameter int              DATA_W   = 8,
    parameter int              AW       = 9,
    parameter logic [DATA_W-1:0] ROM_SEED = 8'h3C
) (
    input  chip_sel_t         sel,
    input  logic [AW-1:0]     addr,
    output logic [DATA_W-1:0] dout,
    output logic              oe
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] rom_mem [DEPTH];

    // Fixed contents computed per word.
    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        localparam logic [DATA_W-1:0] INV = (((i >> (AW - 1)) & 1) != 0) ? '1 : '0;
        assign rom_mem[i] = DATA_W'(i) ^ ROM_SEED ^ INV;
    end

    // Output only when the select pair enables the bank.
    always_comb begin
        oe   = sel_active(sel);
        dout = oe ? rom_mem[addr] : '0;
    end

endmodule

// File: rtl/memmap_read_mux.sv
// Module: one-hot OR mux joining the device outputs onto one read bus.
// Assumes at most one enable is high; returns zero when none is.
module memmap_read_mux #(
    parameter int N_DEV  = 5,
    parameter int DATA_W = 8
) (
    input  logic [N_DEV-1:0]             oe,
    input  logic [N_DEV-1:0][DATA_W-1:0] din,
    output logic [DATA_W-1:0]            dout,
    output logic                         any_oe
);
    // AND-OR reduction across devices.
    always_comb begin
        dout   = '0;
        any_oe = |oe;
        for (int i = 0; i < N_DEV; i++) begin
            dout = dout | (din[i] & {DATA_W{oe[i]}});
        end
    end

endmodule

// File: rtl/memmap_decoder.sv
// Module: top of the chip-select memory subsystem.
// Assumes a single clock; writes and the error flag are the only state
// updated on the edge, reads are combinational from the selected bank.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                RAM_AW    = 7,
    parameter int                ROM_AW    = 9,
    parameter int                RAM_BANKS = 4,
    parameter logic [DATA_W-1:0] ROM_SEED  = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_oe,
    output logic              dec_err
);
    localparam int N_DEV   = RAM_BANKS + 1;
    localparam int ROM_IDX = RAM_BANKS;

    chip_sel_t [RAM_BANKS-1:0]       ram_sel;
    chip_sel_t                       rom_sel;
    logic                            in_map;
    logic [N_DEV-1:0]                dev_oe;
    logic [N_DEV-1:0][DATA_W-1:0]    dev_data;

    memmap_addr_decode #(
        .ADDR_W   (ADDR_W),
        .RAM_AW   (RAM_AW),
        .ROM_AW   (ROM_AW),
        .RAM_BANKS(RAM_BANKS)
    ) u_decode (
        .addr   (addr),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .ram_sel(ram_sel),
        .rom_sel(rom_sel),
        .in_map (in_map)
    );

    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_ram
        memmap_ram_bank #(
            .DATA_W(DATA_W),
            .AW    (RAM_AW)
        ) u_bank (
            .clk  (clk),
            .sel  (ram_sel[b]),
            .rd_en(rd_en),
            .wr_en(wr_en),
            .addr (addr[RAM_AW-1:0]),
            .wdata(wdata),
            .dout (dev_data[b]),
            .oe   (dev_oe[b])
        );
    end

    memmap_rom_bank #(
        .DATA_W  (DATA_W),
        .AW      (ROM_AW),
        .ROM_SEED(ROM_SEED)
    ) u_rom (
        .sel (rom_sel),
        .addr(addr[ROM_AW-1:0]),
        .dout(dev_data[ROM_IDX]),
        .oe  (dev_oe[ROM_IDX])
    );

    memmap_read_mux #(
        .N_DEV (N_DEV),
        .DATA_W(DATA_W)
    ) u_mux (
        .oe    (dev_oe),
        .din   (dev_data),
        .dout  (rdata),
        .any_oe(rd_oe)
    );

    // Error flag: out-of-map access or write into the read-only region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_err <= 1'b0;
        end else begin
            dec_err <= (rd_en | wr_en) & (~in_map | (wr_en & addr[ROM_AW]));
        end
    end

endmodule

// File: rtl/memmap_decoder_chk.sv
// Module: property checker bound to the top; watches ports and the
// per-device enables. Assumes the error flag is registered.
module memmap_decoder_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int UPPER_LSB = 10,
    parameter int N_DEV     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_oe,
    input logic              dec_err,
    input logic [N_DEV-1:0]  dev_oe
);
    logic in_map;
    assign in_map = (addr[ADDR_W-1:UPPER_LSB] == '0);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_oe)); // R9
    AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (rd_en && !wr_en && in_map)); // R9
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!rd_oe && rdata == '0)); // R3
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rdata == '0)); // R7
    AST_OUT_OF_MAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !in_map) |=> dec_err); // R6
    AST_ROM_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_map && addr[UPPER_LSB-1]) |=> dec_err); // R5
    AST_IDLE_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> !dec_err); // R7
    AST_RESET_FLAG: assert property (@(posedge clk)
        !rst_n |=> !dec_err); // R8

endmodule

bind memmap_decoder memmap_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .UPPER_LSB(ROM_AW + 1),
    .N_DEV    (RAM_BANKS + 1)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .rdata  (rdata),
    .rd_oe  (rd_oe),
    .dec_err(dec_err),
    .dev_oe (dev_oe)
);

// File: tb/memmap_decoder_tb.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops and compares.
module memmap_decoder_tb;
    localparam logic [7:0] SEED = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rd_oe;
    logic        dec_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] rdata;
        logic       oe;
        logic       err;
        string      tag;
    } exp_t;

    exp_t       q[$];
    logic [7:0] model [512];
    logic       prev_err = 1'b0;

    always #4 clk = ~clk;

    memmap_decoder #(.ROM_SEED(SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .rd_oe(rd_oe), .dec_err(dec_err)
    );

    function automatic logic [7:0] rom_val(input logic [8:0] a);
        return a[7:0] ^ SEED ^ (a[8] ? 8'hFF : 8'h00);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: one bus transaction per cycle, expected values pushed to queue.
    task automatic xact(input logic [15:0] a, input logic r, input logic w,
                        input logic [7:0] d, input string tag);
        exp_t e;
        logic ok;
        ok = (a[15:10] == 6'd0);
        @(negedge clk);
        addr = a; rd_en = r; wr_en = w; wdata = d;
        e.tag   = tag;
        e.err   = prev_err;
        e.oe    = r & ~w & ok;
        e.rdata = e.oe ? (a[9] ? rom_val(a[8:0]) : model[a[8:0]]) : 8'h00;
        prev_err = (r | w) & (~ok | (w & a[9]));
        if (w && ok && !a[9]) model[a[8:0]] = d;
        q.push_back(e);
    endtask

    // Monitor: compares settled outputs mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "rdata", rdata, e.rdata);
                check(e.tag, "rd_oe", {7'd0, rd_oe}, {7'd0, e.oe});
                check(e.tag, "dec_err", {7'd0, dec_err}, {7'd0, e.err});
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8", "dec_err in reset", {7'd0, dec_err}, 8'd0);
        check("R7", "rd_oe in reset", {7'd0, rd_oe}, 8'd0);
        rst_n = 1'b1;

        xact(16'h0000, 0, 0, 8'h00, "R7");
        // R1: same offset in each bank holds its own byte
        for (int b = 0; b < 4; b++) xact(16'(b * 128 + 5), 0, 1, 8'(8'h10 + b), "R1");
        for (int b = 0; b < 4; b++) xact(16'(b * 128 + 5), 1, 0, 8'h00, "R1");
        xact(16'h0000, 0, 1, 8'h11, "R1");
        xact(16'h007F, 0, 1, 8'hAA, "R1");
        xact(16'h0080, 0, 1, 8'hBB, "R1");
        xact(16'h01FF, 0, 1, 8'hCC, "R1");
        xact(16'h0000, 1, 0, 8'h00, "R1");
        xact(16'h007F, 1, 0, 8'h00, "R1");
        xact(16'h0080, 1, 0, 8'h00, "R1");
        xact(16'h01FF, 1, 0, 8'h00, "R1");
        // R2: write then read back, overwrite
        xact(16'h0033, 0, 1, 8'h77, "R2");
        xact(16'h0033, 1, 0, 8'h00, "R2");
        xact(16'h0033, 0, 1, 8'h78, "R2");
        xact(16'h0033, 1, 0, 8'h00, "R2");
        // R3: read and write together
        xact(16'h0033, 1, 1, 8'h99, "R3");
        xact(16'h0033, 1, 0, 8'h00, "R3");
        // R4: read-only pattern, both halves and edges
        xact(16'h0200, 1, 0, 8'h00, "R4");
        xact(16'h0255, 1, 0, 8'h00, "R4");
        xact(16'h02FF, 1, 0, 8'h00, "R4");
        xact(16'h0300, 1, 0, 8'h00, "R4");
        xact(16'h03FF, 1, 0, 8'h00, "R4");
        // R5: write to read-only is dropped and flagged
        xact(16'h0210, 0, 1, 8'h00, "R5");
        xact(16'h0210, 1, 0, 8'h00, "R5");
        xact(16'h0000, 0, 0, 8'h00, "R5");
        xact(16'h0000, 0, 0, 8'h00, "R7");
        // R6: out-of-map accesses
        xact(16'h0005, 0, 1, 8'h42, "R6");
        xact(16'h0400, 1, 0, 8'h00, "R6");
        xact(16'h0405, 0, 1, 8'hEE, "R6");
        xact(16'h0005, 1, 0, 8'h00, "R6");
        xact(16'h8000, 1, 0, 8'h00, "R6");
        xact(16'hFC00, 0, 1, 8'h55, "R6");
        xact(16'h0000, 1, 0, 8'h00, "R6");
        // R9: qualified output enable across regions
        xact(16'h0180, 0, 1, 8'h3E, "R9");
        xact(16'h0180, 1, 0, 8'h00, "R9");
        xact(16'h0380, 1, 0, 8'h00, "R9");
        xact(16'h0380, 0, 0, 8'h00, "R9");
        xact(16'h0000, 0, 0, 8'h00, "R7");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule